// File: doc/BRIEF.md
# Interleaved two-channel ADC sample demultiplexer

This block lets one successive-approximation converter serve two analog inputs. It drives the select line of the analog input multiplexer and issues start-of-conversion pulses. It listens to the converter's end-of-sampling and end-of-conversion strobes. Each 12-bit result is written into one of two sample buffers, one per channel. Each buffer therefore holds only its own channel's samples, in time order, and nothing downstream has to separate interleaved data.

The select line flips when sampling ends, so the next input settles while the current conversion is still running. The result of that conversion goes to a buffer chosen by a separate toggle that flips on each end-of-conversion. A capture is a fixed number of conversions, split evenly between the channels, and ends with a one-cycle done interrupt. In circular mode the block rewinds and keeps running. An optional settling wait can be placed between each end-of-conversion and the next start pulse.

Top module: `adc_pair_demux`

## Requirements
- R1: While reset is held and after it is released, `mux_sel`, `soc`, `wr_en_a`, `wr_en_b`, `busy` and `done_irq` are all 0.
- R2: A `start` pulse seen while idle sets `busy` and gives a one-cycle `soc` on the next cycle. It also sets `mux_sel` to 0 (input A) and rewinds both write pointers and the sample count to zero.
- R3: `start` has no effect while `busy` is high. The capture continues with unchanged addresses and channel order.
- R4: The asynchronous strobes `eos_in` and `eoc_in` are resynchronised. The effect of a rising strobe that is first sampled on clock edge k appears at the outputs after edge k+2.
- R5: While busy, each end-of-sampling strobe inverts `mux_sel` (0 = input A, 1 = input B). While idle it is ignored.
- R6: While busy, each end-of-conversion strobe writes exactly one buffer. The first write after start goes to buffer A (`wr_en_a`), the next to buffer B (`wr_en_b`), and so on alternately, whatever `mux_sel` shows.
- R7: Each buffer's write address starts at 0 and rises by one after every write to that buffer. `wr_data` is the 12-bit result zero-extended to 16 bits.
- R8: After each non-final end-of-conversion, `soc` pulses in the same cycle as the write when `settle_en` is 0. When `settle_en` is 1, it pulses `SETTLE_CYCLES` cycles later.
- R9: The write that completes 2·`SAMPLES_PER_CH` conversions comes with a one-cycle `done_irq`. With `circ_mode` at 0, `busy` drops in that cycle and no further `soc` is issued.
- R10: After a capture has ended, further strobes produce no buffer write.
- R11: With `circ_mode` at 1, the terminal write still raises `done_irq`, but `busy` stays high and `soc` continues. Both write pointers return to 0 and the next write goes to buffer A.
- R12: An end-of-sampling and an end-of-conversion that take effect in the same cycle both act: the select flips and the result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a capture (synchronous pulse) |
| circ_mode | input | 1 | 1: rewind and continue after a full capture |
| settle_en | input | 1 | 1: insert the settling wait before each start-of-conversion |
| eos_in | input | 1 | Converter end-of-sampling strobe (asynchronous) |
| eoc_in | input | 1 | Converter end-of-conversion strobe (asynchronous) |
| conv_data | input | 12 | Converter result, stable while eoc_in is high |
| mux_sel | output | 1 | Analog input select, 0 = A, 1 = B |
| soc | output | 1 | Start-of-conversion pulse |
| wr_en_a | output | 1 | Buffer A write strobe |
| wr_addr_a | output | clog2(SAMPLES_PER_CH) | Buffer A write address |
| wr_en_b | output | 1 | Buffer B write strobe |
| wr_addr_b | output | clog2(SAMPLES_PER_CH) | Buffer B write address |
| wr_data | output | 16 | Result word for the strobed buffer |
| busy | output | 1 | High from accepted start until the capture ends |
| done_irq | output | 1 | One-cycle capture-complete interrupt |

## Verification
An end-of-sampling edge and an end-of-conversion edge can be resolved in the same cycle. In that cycle the select flips while the buffer toggle routes the result. To provoke this, the bench raises both strobes in the same cycle and checks that the select inverts and that the write goes to the buffer the alternation calls for. A second overlap occurs when a `start` pulse lands in the middle of a capture. The reference model then expects the pointers and the order to carry on unchanged. A behavioural reference model, keyed by cycle, predicts every output in every cycle.

// File: rtl/adc_pair_demux.sv
module adc_pair_demux #(
  parameter int SAMPLES_PER_CH = 2040,
  parameter int DATA_W         = 12,
  parameter int WORD_W         = 16,
  parameter int SETTLE_CYCLES  = 75
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              circ_mode,
  input  logic                              settle_en,
  input  logic                              eos_in,
  input  logic                              eoc_in,
  input  logic [DATA_W-1:0]                 conv_data,
  output logic                              mux_sel,
  output logic                              soc,
  output logic                              wr_en_a,
  output logic [$clog2(SAMPLES_PER_CH)-1:0] wr_addr_a,
  output logic                              wr_en_b,
  output logic [$clog2(SAMPLES_PER_CH)-1:0] wr_addr_b,
  output logic [WORD_W-1:0]                 wr_data,
  output logic                              busy,
  output logic                              done_irq
);
  localparam int TOTAL = 2 * SAMPLES_PER_CH;
  localparam int AW    = $clog2(SAMPLES_PER_CH);
  localparam int CW    = $clog2(TOTAL);
  localparam int DLW   = $clog2(SETTLE_CYCLES + 2);
  localparam bit USE_SETTLE = (SETTLE_CYCLES > 0);

  logic [2:0]     eos_sr, eoc_sr;
  logic           eos_p, eoc_p, accept, last;
  logic [AW-1:0]  ptr_a, ptr_b;
  logic [CW-1:0]  cnt;
  logic [DLW-1:0] dly;
  logic           chan;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      eos_sr <= '0;
      eoc_sr <= '0;
    end else begin
      eos_sr <= {eos_sr[1:0], eos_in};
      eoc_sr <= {eoc_sr[1:0], eoc_in};
    end

  assign eos_p  = eos_sr[1] & ~eos_sr[2];
  assign eoc_p  = eoc_sr[1] & ~eoc_sr[2];
  assign accept = start & ~busy;
  assign last   = (cnt == CW'(TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      soc       <= 1'b0;
      mux_sel   <= 1'b0;
      chan      <= 1'b0;
      ptr_a     <= '0;
      ptr_b     <= '0;
      cnt       <= '0;
      dly       <= '0;
      wr_en_a   <= 1'b0;
      wr_en_b   <= 1'b0;
      wr_addr_a <= '0;
      wr_addr_b <= '0;
      wr_data   <= '0;
      done_irq  <= 1'b0;
    end else begin
      wr_en_a  <= 1'b0;
      wr_en_b  <= 1'b0;
      done_irq <= 1'b0;
      soc      <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        soc     <= 1'b1;
        mux_sel <= 1'b0;
        chan    <= 1'b0;
        ptr_a   <= '0;
        ptr_b   <= '0;
        cnt     <= '0;
        dly     <= '0;
      end else if (busy) begin
        if (eos_p) mux_sel <= ~mux_sel;
        if (dly != '0) begin
          dly <= dly - 1'b1;
          if (dly == DLW'(1)) soc <= 1'b1;
        end
        if (eoc_p) begin
          wr_data <= WORD_W'(conv_data);
          if (!chan) begin
            wr_en_a   <= 1'b1;
            wr_addr_a <= ptr_a;
            ptr_a     <= ptr_a + 1'b1;
          end else begin
            wr_en_b   <= 1'b1;
            wr_addr_b <= ptr_b;
            ptr_b     <= ptr_b + 1'b1;
          end
          chan <= ~chan;
          cnt  <= cnt + 1'b1;
          if (last) begin
            done_irq <= 1'b1;
            cnt      <= '0;
            ptr_a    <= '0;
            ptr_b    <= '0;
            chan     <= 1'b0;
            if (!circ_mode) busy <= 1'b0;
          end
          if (!last || circ_mode) begin
            if (settle_en && USE_SETTLE) dly <= DLW'(SETTLE_CYCLES);
            else soc <= 1'b1;
          end
        end
      end
    end

  logic alt_b;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        alt_b <= 1'b0;
    else if (accept)   alt_b <= 1'b0;
    else if (wr_en_a)  alt_b <= 1'b1;
    else if (wr_en_b)  alt_b <= 1'b0;

  // R6
  one_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_a && wr_en_b));
  // R6
  order_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_a |-> !alt_b);
  // R6
  order_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_b |-> alt_b);
  // R10
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_a || wr_en_b) |-> $past(busy));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);
  // R5
  mux_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> $past(eos_p || accept));

endmodule

// File: tb/test_adc_pair_demux.sv
module test_adc_pair_demux;
  localparam int SPC    = 4;
  localparam int SETTLE = 5;
  localparam int TOTAL  = 2 * SPC;
  localparam int AW     = $clog2(SPC);

  logic clk = 0, rst_n = 0, start = 0, circ_mode = 0, settle_en = 0;
  logic eos_in = 0, eoc_in = 0;
  logic [11:0] conv_data = '0;
  logic mux_sel, soc, wr_en_a, wr_en_b, busy, done_irq;
  logic [AW-1:0] wr_addr_a, wr_addr_b;
  logic [15:0] wr_data;

  adc_pair_demux #(.SAMPLES_PER_CH(SPC), .SETTLE_CYCLES(SETTLE)) i_adc_pair_demux (
    .clk(clk), .rst_n(rst_n), .start(start), .circ_mode(circ_mode), .settle_en(settle_en),
    .eos_in(eos_in), .eoc_in(eoc_in), .conv_data(conv_data), .mux_sel(mux_sel), .soc(soc),
    .wr_en_a(wr_en_a), .wr_addr_a(wr_addr_a), .wr_en_b(wr_en_b), .wr_addr_b(wr_addr_b),
    .wr_data(wr_data), .busy(busy), .done_irq(done_irq));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit ev_start[int];
  bit ev_eos[int];
  bit ev_eoc[int];
  int ev_dat[int];
  int mem_a[SPC];
  int mem_b[SPC];
  int nwr_a = 0, nwr_b = 0, ndone = 0;

  bit e_busy = 0, e_soc = 0, e_mux = 0, e_wa = 0, e_wb = 0, e_done = 0, e_ch = 0;
  int pa = 0, pb = 0, taken = 0, e_aa = 0, e_ab = 0, e_dat = 0, soc_at = -1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void issue_soc();
    if (settle_en) soc_at = cyc + SETTLE;
    else e_soc = 1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      e_busy = 0; e_soc = 0; e_mux = 0; e_wa = 0; e_wb = 0; e_done = 0; e_ch = 0;
      pa = 0; pb = 0; taken = 0; soc_at = -1;
    end else begin
      e_soc = 0; e_wa = 0; e_wb = 0; e_done = 0;
      if (ev_start.exists(cyc) && !e_busy) begin
        e_busy = 1; e_soc = 1; e_mux = 0; e_ch = 0; pa = 0; pb = 0; taken = 0; soc_at = -1;
      end else if (e_busy) begin
        if (ev_eos.exists(cyc)) e_mux = ~e_mux;
        if (soc_at == cyc) e_soc = 1;
        if (ev_eoc.exists(cyc)) begin
          e_dat = ev_dat[cyc];
          if (!e_ch) begin e_wa = 1; e_aa = pa; pa++; end
          else begin e_wb = 1; e_ab = pb; pb++; end
          e_ch = ~e_ch;
          taken++;
          if (taken == TOTAL) begin
            e_done = 1; taken = 0; pa = 0; pb = 0; e_ch = 0;
            if (!circ_mode) e_busy = 0; else issue_soc();
          end else issue_soc();
        end
      end
    end
    check("R2 busy", busy, e_busy);
    check("R8 soc", soc, e_soc);
    check("R5 mux_sel", mux_sel, e_mux);
    check("R6 wr_en_a", wr_en_a, e_wa);
    check("R6 wr_en_b", wr_en_b, e_wb);
    check("R9 done_irq", done_irq, e_done);
    if (wr_en_a && e_wa) begin
      check("R7 wr_addr_a", wr_addr_a, e_aa);
      check("R7 wr_data", wr_data, e_dat);
    end
    if (wr_en_b && e_wb) begin
      check("R7 wr_addr_b", wr_addr_b, e_ab);
      check("R7 wr_data", wr_data, e_dat);
    end
    if (wr_en_a) begin mem_a[wr_addr_a] = wr_data; nwr_a++; end
    if (wr_en_b) begin mem_b[wr_addr_b] = wr_data; nwr_b++; end
    if (done_irq) ndone++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start();
    start = 1; ev_start[cyc + 2] = 1; tick(1); start = 0;
  endtask

  task automatic pulse_eos();
    eos_in = 1; ev_eos[cyc + 4] = 1; tick(2); eos_in = 0; tick(2);
  endtask

  task automatic pulse_eoc(input int d);
    conv_data = 12'(d); eoc_in = 1; ev_eoc[cyc + 4] = 1; ev_dat[cyc + 4] = d & 12'hFFF;
    tick(2); eoc_in = 0; tick(2 + SETTLE + 2);
  endtask

  task automatic conv(input int d);
    pulse_eos();
    pulse_eoc(d);
  endtask

  function automatic int val(input int i);
    return (12'hA03 + i * 37) & 12'hFFF;
  endfunction

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 outputs in reset", {mux_sel, soc, wr_en_a, wr_en_b, busy, done_irq}, 0);
    rst_n = 1;
    tick(3);
    check("R1 outputs after reset", {mux_sel, soc, wr_en_a, wr_en_b, busy, done_irq}, 0);

    // R2, R4, R5, R6, R7, R8 (no settle), R3 and R12 within a capture
    nwr_a = 0; nwr_b = 0; ndone = 0;
    pulse_start();
    tick(2);
    for (int i = 0; i < TOTAL; i++) begin
      if (i == 3) pulse_start();            // R3 ignored while busy
      if (i == 5) begin                     // R12 both strobes land together
        conv_data = 12'(val(i)); eos_in = 1; eoc_in = 1;
        ev_eos[cyc + 4] = 1; ev_eoc[cyc + 4] = 1; ev_dat[cyc + 4] = val(i);
        tick(2); eos_in = 0; eoc_in = 0; tick(4 + SETTLE);
      end else conv(val(i));
    end
    tick(4);
    check("R9 busy low after capture", busy, 0);
    check("R9 one done pulse", ndone, 1);
    check("R6 writes to A", nwr_a, SPC);
    check("R6 writes to B", nwr_b, SPC);
    for (int k = 0; k < SPC; k++) begin
      check("R7 buffer A content", mem_a[k], val(2 * k));
      check("R7 buffer B content", mem_b[k], val(2 * k + 1));
    end

    // R10 strobes after the end
    nwr_a = 0; nwr_b = 0;
    conv(12'h555);
    conv(12'h0AA);
    check("R10 no writes when idle", nwr_a + nwr_b, 0);
    check("R10 still idle", busy, 0);

    // R8 with settling wait
    settle_en = 1; nwr_a = 0; nwr_b = 0; ndone = 0;
    pulse_start();
    tick(2);
    for (int i = 0; i < TOTAL; i++) conv(val(i + 50));
    tick(4);
    check("R8 settle capture writes", nwr_a + nwr_b, TOTAL);
    check("R9 done with settle", ndone, 1);

    // R11 circular
    settle_en = 0; circ_mode = 1; nwr_a = 0; nwr_b = 0; ndone = 0;
    pulse_start();
    tick(2);
    for (int i = 0; i < TOTAL + 3; i++) conv(val(i + 90));
    tick(4);
    check("R11 busy stays high", busy, 1);
    check("R11 done once", ndone, 1);
    check("R11 A writes across wrap", nwr_a, SPC + 2);
    check("R11 rewound A content", mem_a[0], val(TOTAL + 90));
    check("R11 rewound B content", mem_b[0], val(TOTAL + 91));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule